// File: doc/BRIEF.md
# Ring-Side Address Indicator and Strip Control

This block runs beside the received frame stream on the ring side of a ring media access controller, clocked once per byte. It sees a one-cycle strobe each time an end delimiter passes, an address-recognized input from external address-matching logic, and a strip request from that same logic. From these it decides two things: whether the address-recognized indicator symbol that follows the end delimiter is rewritten to its set value, and from which byte frame stripping is in force.

The address-recognized input is looked at once per frame, at a fixed number of byte times after the end delimiter strobe. The strip request is watched on every byte clock, and stripping starts a fixed number of byte times after a request is seen. Stripping holds until the next end delimiter. The timing line that the copy path uses for external matching is not an input here. Symbol encoding, the physical layer and the data buffers belong elsewhere. Software that confirms frames is expected to raise the strip request in the same window as its external copy request.

Top module: `ring_ind_strip_ctl`

## Requirements
- R1: With the default ADDR_DLY of 2, when `ed_pass` is high at clock edge n and `ext_addr_match` is high at edge n+2, `ind_set` is high for exactly the one cycle after edge n+2.
- R2: `ext_addr_match` has no effect at any edge other than ADDR_DLY edges after an `ed_pass` strobe; `ind_set` never rises without such a strobe.
- R3: When `ext_addr_match` is low at the sample edge, `ind_set` stays low for that frame.
- R4: Each `ed_pass` strobe gets its own sample, so strobes at consecutive edges with the address input high at both sample edges give `ind_set` high for two consecutive cycles.
- R5: `ext_strip_req` is sampled at every edge; with the default STRIP_DLY of 3, a request seen at edge m sets `strip_active` from the cycle after edge m+3, and not earlier.
- R6: `strip_active` stays high until an edge at which `ed_pass` is high and is low after that edge; that clear wins over a start falling on the same edge.
- R7: An end delimiter does not cancel requests still in flight: a request seen in the STRIP_DLY edges before the strobe starts stripping on schedule after the clear.
- R8: Synchronous active-high `rst` forces both outputs low and drops every pending delay, so strobes and requests seen before reset have no effect afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| ed_pass | input | 1 | One-cycle strobe as an end delimiter passes |
| ext_addr_match | input | 1 | External address-recognized input |
| ext_strip_req | input | 1 | External strip request |
| ind_set | output | 1 | One-cycle pulse: send the address indicator as set |
| strip_active | output | 1 | Frame stripping in force |

## Verification
The bound checker watches on every cycle that an indicator pulse follows an address input that was high one edge before and no more than ADDR_DLY edges after the latest end delimiter, that stripping only starts within STRIP_DLY edges of a request, that it holds until and drops right after an end delimiter, and that reset clears both outputs. The exact sample edge, the lack of effect of the address input at neighbouring edges, back-to-back strobes, requests that survive a clear, and the loss of pending work across reset are shown only by the bench's cycle table and directed reset scenario.

// File: rtl/ring_ctl_pkg.sv
package ring_ctl_pkg;
  // Default byte-time offsets of the ring-side controls.
  localparam int unsigned ADDR_SAMPLE_DLY = 2;
  localparam int unsigned STRIP_START_DLY = 3;
endpackage

// File: rtl/rc_delay_line.sv
// Single-bit delay line with synchronous clear; out is in delayed DEPTH edges.
module rc_delay_line #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] stage_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= {stage_q[DEPTH-2:0], din};
      end
    end
  endgenerate

  assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/rc_ind_sampler.sv
// Registers the address-recognized input at the sample strobe.
module rc_ind_sampler (
  input  logic clk,
  input  logic rst,
  input  logic sample_now,
  input  logic addr_match,
  output logic ind_set
);
  always_ff @(posedge clk) begin
    if (rst) ind_set <= 1'b0;
    else     ind_set <= sample_now & addr_match;
  end
endmodule

// File: rtl/rc_strip_ctrl.sv
// Strip-active state: set by a matured request, cleared by an end delimiter.
module rc_strip_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start_now,
  input  logic ed_pass,
  output logic strip_active
);
  always_ff @(posedge clk) begin
    if (rst)            strip_active <= 1'b0;
    else if (ed_pass)   strip_active <= 1'b0;
    else if (start_now) strip_active <= 1'b1;
  end
endmodule

// File: rtl/ring_ind_strip_ctl.sv
module ring_ind_strip_ctl #(
  parameter int unsigned ADDR_DLY  = ring_ctl_pkg::ADDR_SAMPLE_DLY,
  parameter int unsigned STRIP_DLY = ring_ctl_pkg::STRIP_START_DLY
) (
  input  logic clk,
  input  logic rst,
  input  logic ed_pass,
  input  logic ext_addr_match,
  input  logic ext_strip_req,
  output logic ind_set,
  output logic strip_active
);
  logic addr_sample_now;
  logic strip_start_now;

  // Delay from end-delimiter strobe to the address sample edge.
  rc_delay_line #(.DEPTH(ADDR_DLY)) u_ed_dly (
    .clk  (clk),
    .rst  (rst),
    .din  (ed_pass),
    .dout (addr_sample_now)
  );

  // Strip request is watched every edge and matures STRIP_DLY edges later.
  rc_delay_line #(.DEPTH(STRIP_DLY)) u_strip_dly (
    .clk  (clk),
    .rst  (rst),
    .din  (ext_strip_req),
    .dout (strip_start_now)
  );

  rc_ind_sampler u_ind (
    .clk        (clk),
    .rst        (rst),
    .sample_now (addr_sample_now),
    .addr_match (ext_addr_match),
    .ind_set    (ind_set)
  );

  rc_strip_ctrl u_strip (
    .clk          (clk),
    .rst          (rst),
    .start_now    (strip_start_now),
    .ed_pass      (ed_pass),
    .strip_active (strip_active)
  );
endmodule

// File: rtl/ring_ind_strip_ctl_chk.sv
module ring_ind_strip_ctl_chk #(
  parameter int unsigned ADDR_DLY  = 2,
  parameter int unsigned STRIP_DLY = 3
) (
  input logic clk,
  input logic rst,
  input logic ed_pass,
  input logic ext_addr_match,
  input logic ext_strip_req,
  input logic ind_set,
  input logic strip_active
);
  localparam int CW = 8;
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] since_ed;
  logic [CW-1:0] since_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_ed  <= SAT;
      since_req <= SAT;
    end else begin
      since_ed  <= ed_pass ? '0 : ((since_ed == SAT) ? SAT : since_ed + 1'b1);
      since_req <= ext_strip_req ? '0 : ((since_req == SAT) ? SAT : since_req + 1'b1);
    end
  end

  // R1 / R2: a pulse lies within ADDR_DLY edges of the latest strobe.
  a_r1_ind_after_ed: assert property (@(posedge clk) disable iff (rst)
    ind_set |-> (since_ed <= CW'(ADDR_DLY)));

  // R3: a pulse needs the address input high at its sample edge.
  a_r3_ind_needs_addr: assert property (@(posedge clk) disable iff (rst)
    ind_set |-> $past(ext_addr_match));

  // R5: stripping starts only within STRIP_DLY edges of a request.
  a_r5_strip_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(strip_active) |-> (since_req <= CW'(STRIP_DLY)));

  // R6: an end delimiter drops stripping.
  a_r6_strip_clear: assert property (@(posedge clk) disable iff (rst)
    ed_pass |=> !strip_active);

  // R6: stripping holds without an end delimiter.
  a_r6_strip_hold: assert property (@(posedge clk) disable iff (rst)
    (strip_active && !ed_pass) |=> strip_active);

  // R8: reset clears both outputs.
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!ind_set && !strip_active));
endmodule

bind ring_ind_strip_ctl ring_ind_strip_ctl_chk #(
  .ADDR_DLY  (ADDR_DLY),
  .STRIP_DLY (STRIP_DLY)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .ed_pass        (ed_pass),
  .ext_addr_match (ext_addr_match),
  .ext_strip_req  (ext_strip_req),
  .ind_set        (ind_set),
  .strip_active   (strip_active)
);

// File: tb/ring_ind_strip_ctl_tb.sv
module ring_ind_strip_ctl_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 30;

  // Entry: {ed, addr, strip, exp_ind, exp_strip}; outputs are after this edge.
  localparam logic [4:0] VEC [NVEC] = '{
    5'b100_00, // 0  strobe A
    5'b000_00, // 1
    5'b010_10, // 2  R1 sample of A high -> pulse
    5'b000_00, // 3  R1 pulse lasts one cycle
    5'b110_00, // 4  strobe B, addr at strobe edge ignored (R2)
    5'b010_00, // 5  R2 one edge early ignored
    5'b000_00, // 6  R3 sample of B low
    5'b010_00, // 7  R2 one edge late ignored
    5'b001_00, // 8  strip request
    5'b000_00, // 9
    5'b000_00, // 10 R5 not yet
    5'b000_01, // 11 R5 starts
    5'b000_01, // 12 R6 holds
    5'b100_00, // 13 R6 strobe C clears
    5'b001_00, // 14 request before next strobe
    5'b010_10, // 15 R1 sample of C high
    5'b100_00, // 16 strobe D
    5'b000_01, // 17 R7 request of 14 survives clear
    5'b000_01, // 18 R3 sample of D low
    5'b101_00, // 19 strobe E with request
    5'b110_00, // 20 strobe F
    5'b010_10, // 21 R4 sample of E
    5'b010_11, // 22 R4 sample of F, request of 19 starts
    5'b000_01, // 23
    5'b001_01, // 24 request
    5'b000_01, // 25
    5'b000_01, // 26
    5'b100_00, // 27 R6 clear wins over start
    5'b000_00, // 28
    5'b000_00  // 29
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ed_pass = 1'b0;
  logic ext_addr_match = 1'b0;
  logic ext_strip_req = 1'b0;
  logic ind_set;
  logic strip_active;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  ring_ind_strip_ctl u_dut (
    .clk            (clk),
    .rst            (rst),
    .ed_pass        (ed_pass),
    .ext_addr_match (ext_addr_match),
    .ext_strip_req  (ext_strip_req),
    .ind_set        (ind_set),
    .strip_active   (strip_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp, input int idx);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s step %0d: actual %b expected %b", req, idx, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic a, input logic s);
    @(negedge clk);
    ed_pass = e; ext_addr_match = a; ext_strip_req = s;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R8 reset ind", ind_set, 1'b0, -1);
    check("R8 reset strip", strip_active, 1'b0, -1);

    // Table walk covering R1..R7.
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][4], VEC[i][3], VEC[i][2]);
      check("R1-R4 ind_set", ind_set, VEC[i][1], i);
      check("R5-R7 strip_active", strip_active, VEC[i][0], i);
    end

    // R8: pending strobe and request dropped by reset.
    step(1'b1, 1'b0, 1'b1);
    @(negedge clk);
    rst = 1'b1; ed_pass = 1'b0; ext_strip_req = 1'b0; ext_addr_match = 1'b1;
    @(posedge clk); #1;
    check("R8 ind in reset", ind_set, 1'b0, 100);
    check("R8 strip in reset", strip_active, 1'b0, 100);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 1'b1, 1'b0);
      check("R8 ind after reset", ind_set, 1'b0, 101 + k);
      check("R8 strip after reset", strip_active, 1'b0, 101 + k);
    end

    // R5: request held high keeps stripping up; R6 clear then R7 restart.
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    check("R5 held not yet", strip_active, 1'b0, 200);
    step(1'b0, 1'b0, 1'b1);
    check("R5 held start", strip_active, 1'b1, 201);
    step(1'b1, 1'b0, 1'b1);
    check("R6 clear under held req", strip_active, 1'b0, 202);
    step(1'b0, 1'b0, 1'b0);
    check("R7 restart next edge", strip_active, 1'b1, 203);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule